// File: doc/BRIEF.md
# 16-bit Accumulator Virtual-ISA Core

This block executes a compact 16-bit accumulator instruction set out of a byte-wide, byte-addressed memory with a 16-bit address. It holds an accumulator, a program counter and a link register. Every instruction is an opcode byte followed by one operand byte, called D here. The wide-immediate load is the one exception: it is followed by two bytes, low byte first. The first 256 bytes of memory form the zero page. The zero page holds byte variables, and it holds 16-bit words as little-endian pairs at D and D+1.

The program counter always points two bytes behind the next opcode. A fetch first adds 2 to it and then reads at the new value. For this reason, jump and return targets are reduced by 2 before they are loaded into it. The core uses one synchronous memory port that returns read data on the cycle after the address. Instructions take several cycles, and each cycle makes at most one memory access. An opcode outside the implemented set stops the core and raises `halt`, which stays high until reset.

Top module: `vacc_core`

## Requirements
- R1: While `rst` is high, `halt` and `mem_we` are 0. On the first cycle after `rst` falls, the core presents a fetch at RESET_PC+2, which is 0x0200 by default.
- R2: A fetch reads the opcode at address P and then the operand at P+1. The next fetch is at P+2. The wide-immediate load 0x11 takes three bytes, so the next fetch after it is at P+3.
- R3: Opcode 0x1A loads the zero-page byte at D and clears the upper accumulator byte. Opcode 0x59 loads D in the same zero-extended way. Opcode 0x5E writes only the low accumulator byte to zero-page D.
- R4: Opcode 0x21 loads a word, taking the low byte from zero-page D and the high byte from D+1. Opcode 0x2B stores the accumulator the same way. D+1 wraps inside the zero page, so D=0xFF pairs with address 0x00.
- R5: Opcode 0x11 loads the accumulator with the 16-bit value given by the two bytes after the opcode, low byte first.
- R6: Opcodes 0x99 (add), 0xB8 (subtract), 0xF8 (AND), 0xFA (OR) and 0xFC (XOR) combine the accumulator with the zero-page word at D. Add and subtract wrap modulo 2^16.
- R7: Opcodes 0xE3 (add), 0xE6 (subtract), 0x82 (AND), 0x88 (OR) and 0x8C (XOR) apply D, zero-extended to 16 bits, to the accumulator. As a result, AND clears the upper byte and OR/XOR keep it.
- R8: Opcode 0x93 adds 1 to the zero-page byte at D, wrapping within 8 bits without changing D+1. Opcode 0xE9 shifts the accumulator left by one bit, discarding bit 15 and filling bit 0 with 0.
- R9: Opcode 0xAD loads the byte at the address held in the accumulator, zero-extended. Opcode 0xF6 loads the little-endian word at that address and the next one.
- R10: Opcode 0xF0 writes the low accumulator byte to the address held in the zero-page word at D. Opcode 0xF3 writes the whole accumulator there, low byte at the pointer and high byte at pointer+1, with a carry across the 16-bit address.
- R11: Opcode 0xCF saves the address of the following instruction as the return address and continues at the address held in the zero-page word at D. Opcode 0xFF continues at the saved return address.
- R12: Opcode 0x90 replaces only the low byte of the program counter with D, so the next fetch is at {page, D}+2. The page byte stays the same even when the branch itself sits at the end of a page.
- R13: Any other opcode, for example 0x00 or 0x7F, raises `halt`. After that the core makes no write and runs no further instruction until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for the address of the previous cycle |
| mem_we | output | 1 | Write strobe for the current address |
| halt | output | 1 | Undefined opcode seen; core stopped |

## Verification
The embedded properties take two things for granted. First, the memory answers every address with data exactly one cycle later. Second, a write and a read never target the same location in the same cycle in a way that would matter. The checks on the branch, return and load results compare the register state with the operand byte the core sampled one cycle earlier, so the properties depend on that one-cycle latency.

The bench memory model is a 4 KB array. It registers read data on every rising edge and commits writes on the same edge. All programs, data and pointers stay below address 0x1000, so the modelled address window never aliases. Reset is held for two full edges before each program runs.

// File: rtl/vacc_core.sv
module vacc_core #(
  parameter logic [15:0] RESET_PC = 16'h01FE
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic        halt
);

  localparam int AW = 16;
  localparam int BW = 8;

  localparam logic [BW-1:0] OP_LDWI = 8'h11;
  localparam logic [BW-1:0] OP_LD   = 8'h1A;
  localparam logic [BW-1:0] OP_LDW  = 8'h21;
  localparam logic [BW-1:0] OP_STW  = 8'h2B;
  localparam logic [BW-1:0] OP_LDI  = 8'h59;
  localparam logic [BW-1:0] OP_ST   = 8'h5E;
  localparam logic [BW-1:0] OP_ANDI = 8'h82;
  localparam logic [BW-1:0] OP_ORI  = 8'h88;
  localparam logic [BW-1:0] OP_XORI = 8'h8C;
  localparam logic [BW-1:0] OP_BRA  = 8'h90;
  localparam logic [BW-1:0] OP_INC  = 8'h93;
  localparam logic [BW-1:0] OP_ADDW = 8'h99;
  localparam logic [BW-1:0] OP_PEEK = 8'hAD;
  localparam logic [BW-1:0] OP_SUBW = 8'hB8;
  localparam logic [BW-1:0] OP_CALL = 8'hCF;
  localparam logic [BW-1:0] OP_ADDI = 8'hE3;
  localparam logic [BW-1:0] OP_SUBI = 8'hE6;
  localparam logic [BW-1:0] OP_LSLW = 8'hE9;
  localparam logic [BW-1:0] OP_POKE = 8'hF0;
  localparam logic [BW-1:0] OP_DOKE = 8'hF3;
  localparam logic [BW-1:0] OP_DEEK = 8'hF6;
  localparam logic [BW-1:0] OP_ANDW = 8'hF8;
  localparam logic [BW-1:0] OP_ORW  = 8'hFA;
  localparam logic [BW-1:0] OP_XORW = 8'hFC;
  localparam logic [BW-1:0] OP_RET  = 8'hFF;

  typedef enum logic [3:0] {
    S_FETCH, S_OPC, S_DEC, S_ZLO, S_ZHI, S_WHI,
    S_PTRHI, S_IMMHI, S_PLO, S_PHI, S_HALT
  } state_t;

  state_t        state;
  logic [AW-1:0] pc, lr, acc, ptr;
  logic [BW-1:0] op, dzp, tmp;

  wire [AW-1:0] zword = {mem_rdata, tmp};
  wire [AW-1:0] dimm  = {8'h00, mem_rdata};

  assign halt = (state == S_HALT);

  always_comb begin
    mem_addr  = pc + 16'd2;
    mem_wdata = acc[7:0];
    mem_we    = 1'b0;
    case (state)
      S_FETCH: mem_addr = pc + 16'd2;
      S_OPC:   mem_addr = pc + 16'd1;
      S_DEC: begin
        case (op)
          OP_ST, OP_STW: begin
            mem_addr = {8'h00, mem_rdata};
            mem_we   = 1'b1;
          end
          OP_LDWI:          mem_addr = pc + 16'd2;
          OP_PEEK, OP_DEEK: mem_addr = acc;
          default:          mem_addr = {8'h00, mem_rdata};
        endcase
      end
      S_ZLO: begin
        if (op == OP_INC) begin
          mem_addr  = {8'h00, dzp};
          mem_wdata = mem_rdata + 8'd1;
          mem_we    = 1'b1;
        end else begin
          mem_addr = {8'h00, dzp + 8'd1};
        end
      end
      S_ZHI: begin
        if (op == OP_POKE || op == OP_DOKE) begin
          mem_addr = zword;
          mem_we   = 1'b1;
        end
      end
      S_WHI: begin
        mem_addr  = {8'h00, dzp + 8'd1};
        mem_wdata = acc[15:8];
        mem_we    = 1'b1;
      end
      S_PTRHI: begin
        mem_addr  = ptr + 16'd1;
        mem_wdata = acc[15:8];
        mem_we    = 1'b1;
      end
      S_PLO:   mem_addr = acc + 16'd1;
      S_HALT:  mem_addr = pc;
      default: mem_addr = pc + 16'd2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= RESET_PC;
      lr    <= '0;
      acc   <= '0;
      ptr   <= '0;
      op    <= '0;
      dzp   <= '0;
      tmp   <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          pc    <= pc + 16'd2;
          state <= S_OPC;
        end
        S_OPC: begin
          op    <= mem_rdata;
          state <= S_DEC;
        end
        S_DEC: begin
          dzp   <= mem_rdata;
          state <= S_FETCH;
          case (op)
            OP_LDI:  acc <= dimm;
            OP_ADDI: acc <= acc + dimm;
            OP_SUBI: acc <= acc - dimm;
            OP_ANDI: acc <= acc & dimm;
            OP_ORI:  acc <= acc | dimm;
            OP_XORI: acc <= acc ^ dimm;
            OP_LSLW: acc <= {acc[14:0], 1'b0};
            OP_BRA:  pc[7:0] <= mem_rdata;
            OP_RET:  pc <= lr - 16'd2;
            OP_ST:   state <= S_FETCH;
            OP_STW:  state <= S_WHI;
            OP_LDWI: begin
              tmp   <= mem_rdata;
              state <= S_IMMHI;
            end
            OP_PEEK, OP_DEEK: state <= S_PLO;
            OP_LD, OP_LDW, OP_ADDW, OP_SUBW, OP_ANDW, OP_ORW, OP_XORW,
            OP_INC, OP_CALL, OP_POKE, OP_DOKE: state <= S_ZLO;
            default: state <= S_HALT;
          endcase
        end
        S_ZLO: begin
          tmp   <= mem_rdata;
          state <= S_ZHI;
          if (op == OP_LD) begin
            acc   <= dimm;
            state <= S_FETCH;
          end else if (op == OP_INC) begin
            state <= S_FETCH;
          end
        end
        S_ZHI: begin
          state <= S_FETCH;
          case (op)
            OP_LDW:  acc <= zword;
            OP_ADDW: acc <= acc + zword;
            OP_SUBW: acc <= acc - zword;
            OP_ANDW: acc <= acc & zword;
            OP_ORW:  acc <= acc | zword;
            OP_XORW: acc <= acc ^ zword;
            OP_CALL: begin
              lr <= pc + 16'd2;
              pc <= zword - 16'd2;
            end
            OP_DOKE: begin
              ptr   <= zword;
              state <= S_PTRHI;
            end
            default: state <= S_FETCH;
          endcase
        end
        S_IMMHI: begin
          acc   <= zword;
          pc    <= pc + 16'd1;
          state <= S_FETCH;
        end
        S_PLO: begin
          tmp   <= mem_rdata;
          state <= S_PHI;
          if (op == OP_PEEK) begin
            acc   <= dimm;
            state <= S_FETCH;
          end
        end
        S_PHI: begin
          acc   <= zword;
          state <= S_FETCH;
        end
        S_WHI, S_PTRHI: state <= S_FETCH;
        S_HALT:         state <= S_HALT;
        default:        state <= S_HALT;
      endcase
    end
  end

  a_r13_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && !mem_we));

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (pc == $past(pc) + 16'd2));

  a_r12_bra_in_page: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && op == OP_BRA) |=> (pc == {$past(pc[15:8]), $past(mem_rdata)}));

  a_r11_ret_target: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && op == OP_RET) |=> (pc == $past(lr) - 16'd2));

  a_r3_ldi_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && op == OP_LDI) |=> (acc == {8'h00, $past(mem_rdata)}));

  a_r8_shift_left: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && op == OP_LSLW) |=> (acc == {$past(acc[14:0]), 1'b0}));

endmodule

// File: tb/vacc_core_bench.sv
module vacc_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_we;
  logic        halt;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_cnt  = 0;
  logic [15:0] cur;
  logic [7:0]  mem [0:4095];

  always #2 clk = ~clk;

  vacc_core u_vacc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .halt(halt)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[11:0]];
    if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic setb(input logic [15:0] a, input logic [7:0] v);
    mem[a[11:0]] = v;
  endtask

  function automatic logic [15:0] getw(input logic [15:0] a);
    return {mem[a[11:0] + 12'd1], mem[a[11:0]]};
  endfunction

  task automatic start_load();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    cur = 16'h0200;
  endtask

  task automatic ins(input logic [7:0] op, input logic [7:0] d);
    setb(cur, op);
    setb(cur + 16'd1, d);
    cur = cur + 16'd2;
  endtask

  task automatic ldwi(input logic [15:0] v);
    setb(cur, 8'h11);
    setb(cur + 16'd1, v[7:0]);
    setb(cur + 16'd2, v[15:8]);
    cur = cur + 16'd3;
  endtask

  task automatic run(input string req);
    bit done;
    done = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge clk);
      if (halt) done = 1'b1;
    end
    chk({req, " program reaches halt"}, {31'd0, done}, 32'd1);
  endtask

  task automatic test_loads();
    start_load();
    setb(16'h0050, 8'h85);
    setb(16'h0041, 8'hEE);
    setb(16'h0070, 8'h78);
    setb(16'h0071, 8'h56);
    ldwi(16'hABCD);
    ins(8'h5E, 8'h40);
    ins(8'h1A, 8'h50);
    ins(8'h2B, 8'h42);
    ins(8'h59, 8'h9C);
    ins(8'h2B, 8'h44);
    ldwi(16'h1234);
    ins(8'h2B, 8'hFF);
    ins(8'h21, 8'h70);
    ins(8'h2B, 8'h62);
    ins(8'h00, 8'h00);
    run("R3");
    chk("R3 byte store low byte", mem[12'h040], 8'hCD);
    chk("R3 byte store single byte", mem[12'h041], 8'hEE);
    chk("R3 byte load zero-extends", getw(16'h0042), 16'h0085);
    chk("R3 LDI zero-extends", getw(16'h0044), 16'h009C);
    chk("R4 word store wraps D+1 low", mem[12'h0FF], 8'h34);
    chk("R4 word store wraps D+1 high", mem[12'h000], 8'h12);
    chk("R4 word load little-endian", getw(16'h0062), 16'h5678);
  endtask

  task automatic test_word_alu();
    start_load();
    setb(16'h0070, 8'h20); setb(16'h0071, 8'h00);
    setb(16'h0072, 8'h0F); setb(16'h0073, 8'hF0);
    ldwi(16'hFFF0); ins(8'h99, 8'h70); ins(8'h2B, 8'h80);
    ins(8'hB8, 8'h72); ins(8'h2B, 8'h82);
    ldwi(16'h3C5A); ins(8'hF8, 8'h72); ins(8'h2B, 8'h84);
    ldwi(16'h3C5A); ins(8'hFA, 8'h72); ins(8'h2B, 8'h86);
    ldwi(16'h3C5A); ins(8'hFC, 8'h72); ins(8'h2B, 8'h88);
    ins(8'h00, 8'h00);
    run("R6");
    chk("R6 word add wraps", getw(16'h0080), 16'h0010);
    chk("R6 word subtract wraps", getw(16'h0082), 16'h1001);
    chk("R6 word AND", getw(16'h0084), 16'h300A);
    chk("R6 word OR", getw(16'h0086), 16'hFC5F);
    chk("R6 word XOR", getw(16'h0088), 16'hCC55);
    chk("R5 R2 three-byte immediate keeps alignment", getw(16'h0088) ^ 16'hCC55, 16'h0000);
  endtask

  task automatic test_imm();
    start_load();
    ins(8'h59, 8'hF0); ins(8'hE3, 8'h20); ins(8'h2B, 8'h90);
    ins(8'hE6, 8'h11); ins(8'h2B, 8'h92);
    ins(8'h59, 8'h05); ins(8'hE6, 8'h06); ins(8'h2B, 8'h94);
    ldwi(16'h0F0F); ins(8'h82, 8'h3C); ins(8'h2B, 8'h96);
    ldwi(16'h1200); ins(8'h88, 8'h34); ins(8'h2B, 8'h98);
    ins(8'h8C, 8'hFF); ins(8'h2B, 8'h9A);
    ldwi(16'hFFFF); ins(8'h59, 8'h7E); ins(8'h2B, 8'h9C);
    ins(8'h00, 8'h00);
    run("R7");
    chk("R7 add immediate carries", getw(16'h0090), 16'h0110);
    chk("R7 subtract immediate", getw(16'h0092), 16'h00FF);
    chk("R7 subtract immediate wraps", getw(16'h0094), 16'hFFFF);
    chk("R7 AND immediate clears high", getw(16'h0096), 16'h000C);
    chk("R7 OR immediate keeps high", getw(16'h0098), 16'h1234);
    chk("R7 XOR immediate keeps high", getw(16'h009A), 16'h12CB);
    chk("R3 LDI clears high byte", getw(16'h009C), 16'h007E);
  endtask

  task automatic test_inc_shift();
    start_load();
    setb(16'h00A0, 8'hFF);
    setb(16'h00A1, 8'h41);
    ins(8'h93, 8'hA0); ins(8'h93, 8'hA1);
    ldwi(16'h8001); ins(8'hE9, 8'h00); ins(8'h2B, 8'hA2);
    ins(8'hE9, 8'h00); ins(8'h2B, 8'hA4);
    ins(8'h00, 8'h00);
    run("R8");
    chk("R8 increment wraps in 8 bits", mem[12'h0A0], 8'h00);
    chk("R8 increment leaves D+1 alone", mem[12'h0A1], 8'h42);
    chk("R8 shift drops bit 15", getw(16'h00A2), 16'h0002);
    chk("R8 second shift", getw(16'h00A4), 16'h0004);
  endtask

  task automatic test_indirect();
    start_load();
    setb(16'h0300, 8'h9A); setb(16'h0301, 8'hBC);
    setb(16'h00B0, 8'h10); setb(16'h00B1, 8'h03);
    setb(16'h00B2, 8'hFF); setb(16'h00B3, 8'h03);
    setb(16'h0311, 8'hEE);
    ldwi(16'h0300); ins(8'hAD, 8'h00); ins(8'h2B, 8'hC0);
    ldwi(16'h0300); ins(8'hF6, 8'h00); ins(8'h2B, 8'hC2);
    ldwi(16'h5566); ins(8'hF0, 8'hB0); ins(8'hF3, 8'hB2);
    ins(8'h00, 8'h00);
    run("R9");
    chk("R9 byte read zero-extends", getw(16'h00C0), 16'h009A);
    chk("R9 word read little-endian", getw(16'h00C2), 16'hBC9A);
    chk("R10 byte write at pointer", mem[12'h310], 8'h66);
    chk("R10 byte write touches one byte", mem[12'h311], 8'hEE);
    chk("R10 word write low", mem[12'h3FF], 8'h66);
    chk("R10 word write high carries page", mem[12'h400], 8'h55);
  endtask

  task automatic test_call();
    start_load();
    setb(16'h00D0, 8'h00); setb(16'h00D1, 8'h04);
    ins(8'hCF, 8'hD0); ins(8'h59, 8'h77); ins(8'h5E, 8'hD3); ins(8'h00, 8'h00);
    cur = 16'h0400;
    ins(8'h59, 8'h55); ins(8'h5E, 8'hD2); ins(8'hFF, 8'h00);
    run("R11");
    chk("R11 call reaches subroutine", mem[12'h0D2], 8'h55);
    chk("R11 return resumes after call", mem[12'h0D3], 8'h77);
  endtask

  task automatic test_branch();
    start_load();
    ins(8'h90, 8'hFC);
    ins(8'h59, 8'h44); ins(8'h5E, 8'hE0); ins(8'h00, 8'h00);
    cur = 16'h02FE; ins(8'h90, 8'h20);
    cur = 16'h0222; ins(8'h59, 8'h33); ins(8'h5E, 8'hE0); ins(8'h00, 8'h00);
    cur = 16'h0322; ins(8'h59, 8'h55); ins(8'h5E, 8'hE0); ins(8'h00, 8'h00);
    run("R12");
    chk("R12 branch stays in page", mem[12'h0E0], 8'h33);
  endtask

  task automatic test_halt();
    int snap;
    start_load();
    ins(8'h59, 8'h11); ins(8'h5E, 8'hF0); ins(8'h00, 8'h00); ins(8'h5E, 8'hF1);
    run("R13");
    chk("R13 work before halt done", mem[12'h0F0], 8'h11);
    snap = wr_cnt;
    repeat (16) @(negedge clk);
    chk("R13 halt held", {31'd0, halt}, 32'd1);
    chk("R13 no write after halt", wr_cnt, snap);
    chk("R13 next instruction not run", mem[12'h0F1], 8'h00);
    start_load();
    setb(16'h00F0, 8'hAB);
    ins(8'h7F, 8'h00); ins(8'h59, 8'h01); ins(8'h5E, 8'hF0);
    snap = wr_cnt;
    run("R13");
    chk("R13 opcode 0x7F halts without writes", wr_cnt, snap);
    chk("R13 memory untouched", mem[12'h0F0], 8'hAB);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 halt clear in reset", {31'd0, halt}, 32'd0);
    chk("R1 no write in reset", {31'd0, mem_we}, 32'd0);
    rst = 1'b0;
    #1;
    chk("R1 first fetch address", mem_addr, 16'h0200);
    @(negedge clk);
    chk("R2 operand follows opcode", mem_addr, 16'h0201);
    @(negedge clk);
    rst = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_loads();
    test_word_alu();
    test_imm();
    test_inc_shift();
    test_indirect();
    test_call();
    test_branch();
    test_halt();
    test_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule